// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit resolves one source operand for a register-based datapath. A request carries an addressing mode, a base register number, an index register number, a two-bit operand size code and a 16-bit literal. The unit reads the register file through two combinational read ports and forms the effective address. It then fetches the operand through a simple memory read port with a request/valid handshake and returns the value with a one-cycle done strobe.

Ten modes are provided. Two of them need no memory access: register and immediate. Five make a single read: base plus displacement, register indirect, base plus index, absolute, and scaled index. Memory indirect makes two dependent reads. Two modes also update their base register, post-increment and pre-decrement, and issue a register write-back together with done. The unit accepts one request at a time and ignores start while it is busy.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `mem_req`, `wb_en` and `busy` are all low.
- R2: Mode 0 returns the base register value, and mode 1 returns the sign-extended literal. Codes 10 to 15 behave as mode 0. None of these reads memory, and `done` is high in the second cycle after the start edge.
- R3: Single-read modes read memory once, and the operand is the data returned. Mode 2 reads at literal+base, mode 3 at base, mode 4 at base+index and mode 5 at the literal.
- R4: Mode 6 reads at the base value, then reads again at the word returned. The operand is the second word, and exactly two reads are made.
- R5: Mode 7 reads at the base value and writes back base+d, where d = 1 << size code (1, 2, 4, 8).
- R6: Mode 8 computes base−d, reads at that value and writes it back to the base register.
- R7: Mode 9 reads at literal + base + (index << size code).
- R8: `wb_en` is high only for modes 7 and 8. It lasts exactly one cycle, coincides with `done`, and carries `wb_idx` equal to the base register number.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` answers it. `done` is a single-cycle pulse.
- R10: A start pulse while `busy` is high is ignored. The running result is unchanged and no extra result follows.
- R11: The 16-bit literal is sign-extended to 32 bits before any use (bit 15 set gives upper bits all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 4 | Base register number |
| index_sel | input | 4 | Index register number |
| size_code | input | 2 | Operand size code, d = 1 << code |
| literal | input | 16 | Immediate, displacement or absolute address |
| rf_a_addr | output | 4 | Register read port A address (base) |
| rf_a_data | input | 32 | Register read port A data |
| rf_b_addr | output | 4 | Register read port B address (index) |
| rf_b_data | input | 32 | Register read port B data |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Operand valid strobe |
| operand | output | 32 | Resolved operand value |
| wb_en | output | 1 | Base register write-back enable |
| wb_idx | output | 4 | Write-back register number |
| wb_data | output | 32 | Write-back value |

## Verification
On every cycle the assertions check the handshake and strobe rules. They cover the request hold with a steady address, single-cycle done, a write-back only together with done and never two in a row, the two-cycle finish of the non-memory modes, and that a start during busy does not end the operation early. The address arithmetic of each mode, the pointer chase of memory indirect, the read counts, the sign extension and the write-back values are shown only by the bench scenarios. The bench compares each result with its own model of register and memory contents, under several memory latencies.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_REG    = 4'd0,
    AM_IMM    = 4'd1,
    AM_DISP   = 4'd2,
    AM_RIND   = 4'd3,
    AM_IDX    = 4'd4,
    AM_ABS    = 4'd5,
    AM_MIND   = 4'd6,
    AM_AINC   = 4'd7,
    AM_ADEC   = 4'd8,
    AM_SCALED = 4'd9
  } am_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_READ1 = 3'd2,
    ST_READ2 = 3'd3,
    ST_WB    = 3'd4
  } st_e;

  // Modes in the range 2..9 touch memory; everything else is resolved in place.
  function automatic logic am_needs_mem(logic [3:0] m);
    return (m >= AM_DISP) && (m <= AM_SCALED);
  endfunction

  function automatic logic am_is_chain(logic [3:0] m);
    return m == AM_MIND;
  endfunction

  function automatic logic am_updates_base(logic [3:0] m);
    return (m == AM_AINC) || (m == AM_ADEC);
  endfunction

endpackage

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LIT_W = 16
) (
  input  logic [3:0]       mode,
  input  logic [1:0]       size_code,
  input  logic [LIT_W-1:0] literal,
  input  logic [AW-1:0]    base_val,
  input  logic [AW-1:0]    index_val,
  output logic [AW-1:0]    ea,
  output logic [AW-1:0]    direct_val,
  output logic [AW-1:0]    wb_val
);

  function automatic logic [AW-1:0] sext_lit(logic [LIT_W-1:0] v);
    return {{(AW-LIT_W){v[LIT_W-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] size_step(logic [1:0] sc);
    return AW'(1) << sc;
  endfunction

  function automatic logic [AW-1:0] scale_idx(logic [AW-1:0] v, logic [1:0] sc);
    return v << sc;
  endfunction

  logic [AW-1:0] lit_x;
  logic [AW-1:0] step;
  logic [AW-1:0] base_dec;

  assign lit_x    = sext_lit(literal);
  assign step     = size_step(size_code);
  assign base_dec = base_val - step;

  always_comb begin
    ea         = base_val;
    wb_val     = base_val;
    direct_val = base_val;
    case (mode)
      AM_IMM:    direct_val = lit_x;
      AM_DISP:   ea = lit_x + base_val;
      AM_RIND:   ea = base_val;
      AM_IDX:    ea = base_val + index_val;
      AM_ABS:    ea = lit_x;
      AM_MIND:   ea = base_val;
      AM_AINC: begin
        ea     = base_val;
        wb_val = base_val + step;
      end
      AM_ADEC: begin
        ea     = base_dec;
        wb_val = base_dec;
      end
      AM_SCALED: ea = lit_x + base_val + scale_idx(index_val, size_code);
      default:   direct_val = base_val;
    endcase
  end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LIT_W  = 16,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode_in,
  input  logic [RIDX_W-1:0] base_in,
  input  logic [RIDX_W-1:0] index_in,
  input  logic [1:0]        size_in,
  input  logic [LIT_W-1:0]  lit_in,
  output logic [3:0]        mode_q,
  output logic [RIDX_W-1:0] base_q,
  output logic [RIDX_W-1:0] index_q,
  output logic [1:0]        size_q,
  output logic [LIT_W-1:0]  lit_q,
  input  logic [AW-1:0]     ea_in,
  input  logic [AW-1:0]     direct_in,
  input  logic [AW-1:0]     wb_in,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [AW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     operand,
  output logic              wb_en,
  output logic [AW-1:0]     wb_data,
  output logic              ev_accept,
  output logic              ev_read_done
);

  st_e           state, state_nx;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] data_q;
  logic [AW-1:0] wbv_q;
  logic          in_read;

  assign in_read      = (state == ST_READ1) || (state == ST_READ2);
  assign ev_accept    = (state == ST_IDLE) && start;
  assign ev_read_done = in_read && mem_rvalid;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start) state_nx = ST_ADDR;
      ST_ADDR:  state_nx = am_needs_mem(mode_q) ? ST_READ1 : ST_WB;
      ST_READ1: if (mem_rvalid) state_nx = am_is_chain(mode_q) ? ST_READ2 : ST_WB;
      ST_READ2: if (mem_rvalid) state_nx = ST_WB;
      ST_WB:    state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
      size_q  <= '0;
      lit_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wbv_q   <= '0;
    end else begin
      state <= state_nx;
      if (ev_accept) begin
        mode_q  <= mode_in;
        base_q  <= base_in;
        index_q <= index_in;
        size_q  <= size_in;
        lit_q   <= lit_in;
      end
      if (state == ST_ADDR) begin
        addr_q <= ea_in;
        wbv_q  <= wb_in;
        data_q <= direct_in;
      end
      if (ev_read_done) begin
        if ((state == ST_READ1) && am_is_chain(mode_q)) addr_q <= mem_rdata;
        else data_q <= mem_rdata;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign mem_req  = in_read;
  assign mem_addr = addr_q;
  assign done     = (state == ST_WB);
  assign operand  = data_q;
  assign wb_en    = done && am_updates_base(mode_q);
  assign wb_data  = wbv_q;

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LIT_W  = 16,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [RIDX_W-1:0] base_sel,
  input  logic [RIDX_W-1:0] index_sel,
  input  logic [1:0]        size_code,
  input  logic [LIT_W-1:0]  literal,
  output logic [RIDX_W-1:0] rf_a_addr,
  input  logic [AW-1:0]     rf_a_data,
  output logic [RIDX_W-1:0] rf_b_addr,
  input  logic [AW-1:0]     rf_b_data,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [AW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     operand,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [AW-1:0]     wb_data
);

  logic [3:0]        mode_q;
  logic [RIDX_W-1:0] base_q, index_q;
  logic [1:0]        size_q;
  logic [LIT_W-1:0]  lit_q;
  logic [AW-1:0]     ea_w, direct_w, wbv_w;
  logic              ev_accept, ev_read_done;

  ea_addr_gen #(.AW(AW), .LIT_W(LIT_W)) u_gen (
    .mode       (mode_q),
    .size_code  (size_q),
    .literal    (lit_q),
    .base_val   (rf_a_data),
    .index_val  (rf_b_data),
    .ea         (ea_w),
    .direct_val (direct_w),
    .wb_val     (wbv_w)
  );

  ea_ctrl #(.AW(AW), .LIT_W(LIT_W), .RIDX_W(RIDX_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode_in      (mode),
    .base_in      (base_sel),
    .index_in     (index_sel),
    .size_in      (size_code),
    .lit_in       (literal),
    .mode_q       (mode_q),
    .base_q       (base_q),
    .index_q      (index_q),
    .size_q       (size_q),
    .lit_q        (lit_q),
    .ea_in        (ea_w),
    .direct_in    (direct_w),
    .wb_in        (wbv_w),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .busy         (busy),
    .done         (done),
    .operand      (operand),
    .wb_en        (wb_en),
    .wb_data      (wb_data),
    .ev_accept    (ev_accept),
    .ev_read_done (ev_read_done)
  );

  assign rf_a_addr = base_q;
  assign rf_b_addr = index_q;
  assign wb_idx    = base_q;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [3:0]    mode,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          done,
  input logic          wb_en,
  input logic          ev_accept,
  input logic          ev_read_done
);

  // R8: write-back only alongside the done strobe
  a_r8_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R8: never two write-backs back to back
  a_r8_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);

  // R9: done is a one-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: an unanswered request is held with its address
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R2: non-memory modes finish in the second cycle without a request
  a_r2_nonmem_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && (mode <= 4'd1 || mode >= 4'd10)) |=> (!mem_req ##1 (done && !mem_req)));

  // R10: a start during an operation does not end it early
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);

  // R3: a read completes only while a request is pending
  a_r3_read_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_done |-> mem_req);

endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) u_ea_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .mode         (mode),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_rvalid   (mem_rvalid),
  .done         (done),
  .wb_en        (wb_en),
  .ev_accept    (ev_accept),
  .ev_read_done (ev_read_done)
);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [3:0]  base_sel = '0, index_sel = '0;
  logic [1:0]  size_code = '0;
  logic [15:0] literal = '0;
  logic [3:0]  rf_a_addr, rf_b_addr;
  logic [31:0] rf_a_data, rf_b_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done, wb_en;
  logic [31:0] operand, wb_data;
  logic [3:0]  wb_idx;

  always #2 clk = ~clk;

  ea_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .base_sel(base_sel), .index_sel(index_sel), .size_code(size_code),
    .literal(literal), .rf_a_addr(rf_a_addr), .rf_a_data(rf_a_data),
    .rf_b_addr(rf_b_addr), .rf_b_data(rf_b_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .operand(operand), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Register file model, written back from the port
  logic [31:0] regs [16];
  assign rf_a_data = regs[rf_a_addr];
  assign rf_b_data = regs[rf_b_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 32'h1000_0000 + 32'(i) * 32'h0000_0110;
    end else if (wb_en) regs[wb_idx] <= wb_data;
  end

  // Memory model: contents derived from the address, programmable latency
  function automatic logic [31:0] memf(logic [31:0] a);
    return {a[7:0], a[31:8]} ^ 32'h5A5A_0F0F;
  endfunction

  int lat = 0;
  int wcnt = 0;
  int rd_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      wcnt = 0;
    end else if (mem_req && !mem_rvalid) begin
      if (wcnt >= lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= memf(mem_addr);
        rd_cnt++;
        wcnt = 0;
      end else begin
        mem_rvalid <= 1'b0;
        wcnt++;
      end
    end else mem_rvalid <= 1'b0;
  end

  typedef struct {
    logic [31:0] opnd;
    bit          wb;
    logic [31:0] wbd;
    logic [3:0]  wbi;
    int          reads;
    int          rd_base;
    string       req;
  } item_t;

  item_t sb_q[$];
  item_t cur;

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          check(0, "R10", "unexpected done", 32'd1, 32'd0);
        end else begin
          cur = sb_q.pop_front();
          check(operand == cur.opnd, cur.req, "operand", operand, cur.opnd);
          check(wb_en == cur.wb, "R8", {cur.req, " wb_en"}, 32'(wb_en), 32'(cur.wb));
          if (cur.wb) begin
            check(wb_data == cur.wbd, cur.req, "wb_data", wb_data, cur.wbd);
            check(wb_idx == cur.wbi, "R8", "wb_idx", 32'(wb_idx), 32'(cur.wbi));
          end
          check((rd_cnt - cur.rd_base) == cur.reads, cur.req, "read count",
                32'(rd_cnt - cur.rd_base), 32'(cur.reads));
        end
      end
    end
  end

  // Driver: independent model of each mode, pushes expectation, runs op
  task automatic do_op(logic [3:0] m, logic [3:0] a, logic [3:0] b, logic [1:0] sc,
                       logic [15:0] lit, int latency, string req, bit poke = 0);
    item_t it;
    logic [31:0] bv, iv, litv, d, ad;
    int cyc;
    bv   = regs[a];
    iv   = regs[b];
    litv = 32'($signed(lit));
    d    = 32'(2 ** sc);
    it.wb = 0; it.wbd = '0; it.wbi = a; it.reads = 1; it.req = req;
    case (m)
      4'd1: begin it.opnd = litv; it.reads = 0; end
      4'd2: it.opnd = memf(bv + litv);
      4'd3: it.opnd = memf(bv);
      4'd4: it.opnd = memf(iv + bv);
      4'd5: it.opnd = memf(litv);
      4'd6: begin it.opnd = memf(memf(bv)); it.reads = 2; end
      4'd7: begin it.opnd = memf(bv); it.wb = 1; it.wbd = bv + d; end
      4'd8: begin ad = bv - d; it.opnd = memf(ad); it.wb = 1; it.wbd = ad; end
      4'd9: it.opnd = memf(iv * d + litv + bv);
      default: begin it.opnd = bv; it.reads = 0; end
    endcase
    it.rd_base = rd_cnt;
    lat = latency;
    sb_q.push_back(it);
    mode = m; base_sel = a; index_sel = b; size_code = sc; literal = lit;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; mode = 4'd0; base_sel = ~a; literal = ~lit;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (it.reads == 0) check(cyc == 2, "R2", "latency", 32'(cyc), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !mem_req && !wb_en && !busy, "R1", "reset outputs",
          {28'd0, done, mem_req, wb_en, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_req && !wb_en && !busy, "R1", "idle after reset",
          {28'd0, done, mem_req, wb_en, busy}, 32'd0);

    do_op(4'd0, 4'd3, 4'd0, 2'd0, 16'h0000, 0, "R2");
    do_op(4'd1, 4'd0, 4'd0, 2'd0, 16'h0123, 0, "R2");
    do_op(4'd1, 4'd0, 4'd0, 2'd0, 16'h8001, 0, "R11");
    do_op(4'd12, 4'd5, 4'd1, 2'd0, 16'h0000, 0, "R2");
    do_op(4'd2, 4'd4, 4'd0, 2'd0, 16'h0040, 0, "R3");
    do_op(4'd2, 4'd4, 4'd0, 2'd0, 16'hFFF0, 2, "R11");
    do_op(4'd3, 4'd6, 4'd0, 2'd0, 16'h0000, 1, "R3");
    do_op(4'd4, 4'd7, 4'd9, 2'd0, 16'h0000, 0, "R3");
    do_op(4'd5, 4'd0, 4'd0, 2'd0, 16'h7FFC, 3, "R9");
    do_op(4'd6, 4'd2, 4'd0, 2'd0, 16'h0000, 0, "R4");
    do_op(4'd6, 4'd11, 4'd0, 2'd0, 16'h0000, 2, "R4");
    do_op(4'd7, 4'd8, 4'd0, 2'd2, 16'h0000, 0, "R5");
    do_op(4'd7, 4'd8, 4'd0, 2'd3, 16'h0000, 1, "R5");
    do_op(4'd3, 4'd8, 4'd0, 2'd0, 16'h0000, 0, "R5");
    do_op(4'd8, 4'd10, 4'd0, 2'd1, 16'h0000, 0, "R6");
    do_op(4'd8, 4'd10, 4'd0, 2'd0, 16'h0000, 2, "R6");
    for (int s = 0; s < 4; s++)
      do_op(4'd9, 4'd12, 4'd13, 2'(s), 16'hFF80 + 16'(s), s % 3, "R7");
    do_op(4'd6, 4'd1, 4'd0, 2'd0, 16'h0000, 3, "R10", 1);
    do_op(4'd7, 4'd14, 4'd0, 2'd2, 16'h0000, 3, "R10", 1);

    repeat (6) @(negedge clk);
    check(sb_q.size() == 0, "R10", "pending results", 32'(sb_q.size()), 32'd0);
    check(!busy, "R10", "idle after poke", 32'(busy), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule